// File: doc/BRIEF.md
# DDR Burst SRAM Command Scheduler

This block sits on the host side of a bank of double-data-rate burst SRAMs that are expanded in depth. It accepts read and write requests on a valid/ready port. Each request covers one burst of two data beats. For each request it drives the device command pins one cycle later: a per-bank active-low load strobe, a shared read/write select and a shared address. For a write it then drives the two write beats and their active-low byte selects in the following cycle. The bank is chosen by the top address bits. The lower bits go to every bank.

The devices cannot turn the bus around from a read to a write without an idle cycle. The scheduler therefore holds off write requests after a read: by one idle cycle, or by two when `cfg_two_nop_i` is set for high clock rates. Reads after reads, writes after writes and reads after writes issue back to back. A small shift register follows each read burst through the configured return latency. It flags the cycle in which the two returned beats, captured by the PHY, appear on `rd_data_i`. The latency mode (`cfg_half_lat_i`) is a strap. It changes only while no read is in flight.

Top module: `ddr_sram_sched`

## Requirements
- R1: While reset is applied and in the first cycle after it, all load strobes and all byte selects are high (inactive), `rd_valid_o` is low, and `req_ready_o` is high for a read request.
- R2: A request accepted at a clock edge (valid and ready high) appears on the pins in the following cycle. Exactly one `ld_n_o` bit is low, at the index given by the top log2(BANKS) bits of the request address. `addr_o` carries the remaining low bits. `rw_o` is 1 for a read and 0 for a write. In a cycle after an edge with no acceptance, all strobes are high.
- R3: A write command never appears on the pins in the cycle right after a read command. With `cfg_two_nop_i` set, it also never appears two cycles after one. While a write is held off this way, `req_ready_o` is low for a write request.
- R4: A read following any command, and a write following a write, are accepted without an idle cycle; `req_ready_o` stays high for them.
- R5: The hold-off is no longer than needed. A write can be on the pins two cycles after a read command, or three with `cfg_two_nop_i` set.
- R6: In the cycle after a write command, `wd_o` holds the request's two beats (beat 0 in the low half) and `be_n_o` holds the inverted request byte enables (bit i enables byte i, beat 0 in the low half). In every other cycle `be_n_o` is all ones.
- R7: With `cfg_half_lat_i` low, `rd_valid_o` is high in the cycle after a read command is on the pins, and `rd_data_o` equals `rd_data_i` then.
- R8: With `cfg_half_lat_i` high, `rd_valid_o` is high two cycles after a read command is on the pins, with `rd_data_o` equal to `rd_data_i`.
- R9: Every read command yields exactly one `rd_valid_o` cycle, even when more commands follow. `rd_valid_o` is low in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock, one command slot per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_two_nop_i | input | 1 | Add a second idle cycle on read-to-write turnaround |
| cfg_half_lat_i | input | 1 | Read return latency mode strap: 1 = one and a half cycles, 0 = one cycle |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Burst address, bank in the top bits |
| req_wdata_i | input | 2*DATA_W | Write beats, beat 0 low |
| req_be_i | input | 2*BE_W | Active-high byte enables, beat 0 low |
| ld_n_o | output | BANKS | Per-bank active-low load strobe |
| rw_o | output | 1 | Shared select, 1 = read |
| addr_o | output | ADDR_W-log2(BANKS) | Shared device address |
| wd_o | output | 2*DATA_W | Write beats for the data phase |
| be_n_o | output | 2*BE_W | Active-low byte selects for the data phase |
| rd_data_i | input | 2*DATA_W | Both returned read beats from the PHY |
| rd_data_o | output | 2*DATA_W | Returned read beats |
| rd_valid_o | output | 1 | Returned beats valid |

## Verification
The bench targets the turnaround window. A read followed at once by a write must make the write wait, but for exactly one cycle, or two with the second-idle option. A design that counted from acceptance instead of from the pins would either put a write right after a read or waste a cycle. The bench also switches the latency strap after the pipe has drained. A tap on the wrong stage shifts the valid flag by a cycle, and a read that another command pushes out of the pipe drops its flag. It toggles the second-idle option during traffic and drives random byte enables, so a byte select left active outside the data phase, or swapped beats, show at the pins.

// File: rtl/ddr_sched_pkg.sv
package ddr_sched_pkg;
  typedef enum logic {
    CMD_WRITE = 1'b0,
    CMD_READ  = 1'b1
  } cmd_e;

  localparam int unsigned GAP_W   = 2;
  localparam int unsigned MAX_LAT = 2;
endpackage

// File: rtl/ddr_turnaround.sv
module ddr_turnaround
  import ddr_sched_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_issue_i,
  input  logic two_nop_i,
  output logic wr_block_o
);
  localparam logic [GAP_W-1:0] GAP_MAX = '1;

  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] need;

  // cycles since the last read reached the pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            gap_q <= GAP_MAX;
    else if (rd_issue_i)    gap_q <= '0;
    else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
  end

  assign need       = two_nop_i ? GAP_W'(2) : GAP_W'(1);
  assign wr_block_o = gap_q < need;

  assert_block_after_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_issue_i |=> wr_block_o);
endmodule

// File: rtl/ddr_cmd_issue.sv
module ddr_cmd_issue
  import ddr_sched_pkg::*;
#(
  parameter int unsigned BANKS  = 4,
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 18,
  parameter int unsigned BE_W   = 2,
  localparam int unsigned BANK_W = $clog2(BANKS),
  localparam int unsigned DEV_W  = ADDR_W - BANK_W
)(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  accept_i,
  input  logic                  write_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [2*DATA_W-1:0]   wdata_i,
  input  logic [2*BE_W-1:0]     be_i,
  output logic [BANKS-1:0]      ld_n_o,
  output logic                  rw_o,
  output logic [DEV_W-1:0]      addr_o,
  output logic [2*DATA_W-1:0]   wd_o,
  output logic [2*BE_W-1:0]     be_n_o,
  output logic                  rd_cmd_o,
  output logic                  wr_cmd_o
);
  logic [BANK_W-1:0]   bank;
  logic [BANKS-1:0]    ld_n_q;
  cmd_e                rw_q;
  logic [DEV_W-1:0]    addr_q;
  logic                wpend_q;
  logic [2*DATA_W-1:0] wbuf_q, wd_q;
  logic [2*BE_W-1:0]   bebuf_q, be_n_q;

  assign bank = addr_i[ADDR_W-1 -: BANK_W];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ld_n_q[b] <= 1'b1;
      else         ld_n_q[b] <= !(accept_i && bank == BANK_W'(b));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rw_q   <= CMD_READ;
      addr_q <= '0;
    end else if (accept_i) begin
      rw_q   <= write_i ? CMD_WRITE : CMD_READ;
      addr_q <= addr_i[DEV_W-1:0];
    end
  end

  // write data phase trails the command by one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wpend_q <= 1'b0;
      wbuf_q  <= '0;
      bebuf_q <= '0;
      wd_q    <= '0;
      be_n_q  <= '1;
    end else begin
      wpend_q <= accept_i && write_i;
      if (accept_i && write_i) begin
        wbuf_q  <= wdata_i;
        bebuf_q <= be_i;
      end
      be_n_q <= wpend_q ? ~bebuf_q : '1;
      if (wpend_q) wd_q <= wbuf_q;
    end
  end

  assign ld_n_o   = ld_n_q;
  assign rw_o     = rw_q;
  assign addr_o   = addr_q;
  assign wd_o     = wd_q;
  assign be_n_o   = be_n_q;
  assign rd_cmd_o = !(&ld_n_q) && (rw_q == CMD_READ);
  assign wr_cmd_o = !(&ld_n_q) && (rw_q == CMD_WRITE);

  assert_one_bank_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~ld_n_o));
  assert_be_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cmd_o |=> &be_n_o);
endmodule

// File: rtl/ddr_rd_track.sv
module ddr_rd_track
  import ddr_sched_pkg::*;
#(
  parameter int unsigned DATA_W = 18
)(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_cmd_i,
  input  logic                half_lat_i,
  input  logic [2*DATA_W-1:0] rd_data_i,
  output logic [2*DATA_W-1:0] rd_data_o,
  output logic                rd_valid_o
);
  logic [MAX_LAT:1] pipe_q;

  for (genvar s = 1; s <= MAX_LAT; s++) begin : g_stage
    if (s == 1) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[s] <= 1'b0;
        else         pipe_q[s] <= rd_cmd_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[s] <= 1'b0;
        else         pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign rd_valid_o = half_lat_i ? pipe_q[2] : pipe_q[1];
  assign rd_data_o  = rd_data_i;

  assert_full_lat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cmd_i && !half_lat_i) |=> rd_valid_o);
  assert_half_lat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cmd_i && half_lat_i) |=> ##1 rd_valid_o);
endmodule

// File: rtl/ddr_sram_sched.sv
module ddr_sram_sched
  import ddr_sched_pkg::*;
#(
  parameter int unsigned BANKS  = 4,
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 18,
  parameter int unsigned BE_W   = 2,
  localparam int unsigned BANK_W = $clog2(BANKS),
  localparam int unsigned DEV_W  = ADDR_W - BANK_W
)(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_two_nop_i,
  input  logic                cfg_half_lat_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_write_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [2*DATA_W-1:0] req_wdata_i,
  input  logic [2*BE_W-1:0]   req_be_i,
  output logic [BANKS-1:0]    ld_n_o,
  output logic                rw_o,
  output logic [DEV_W-1:0]    addr_o,
  output logic [2*DATA_W-1:0] wd_o,
  output logic [2*BE_W-1:0]   be_n_o,
  input  logic [2*DATA_W-1:0] rd_data_i,
  output logic [2*DATA_W-1:0] rd_data_o,
  output logic                rd_valid_o
);
  logic wr_block, accept, rd_cmd, wr_cmd;

  assign req_ready_o = !(req_write_i && wr_block);
  assign accept      = req_valid_i && req_ready_o;

  ddr_turnaround u_turn (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_issue_i (accept && !req_write_i),
    .two_nop_i  (cfg_two_nop_i),
    .wr_block_o (wr_block)
  );

  ddr_cmd_issue #(
    .BANKS (BANKS), .ADDR_W (ADDR_W), .DATA_W (DATA_W), .BE_W (BE_W)
  ) u_issue (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .write_i  (req_write_i),
    .addr_i   (req_addr_i),
    .wdata_i  (req_wdata_i),
    .be_i     (req_be_i),
    .ld_n_o   (ld_n_o),
    .rw_o     (rw_o),
    .addr_o   (addr_o),
    .wd_o     (wd_o),
    .be_n_o   (be_n_o),
    .rd_cmd_o (rd_cmd),
    .wr_cmd_o (wr_cmd)
  );

  ddr_rd_track #(.DATA_W (DATA_W)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_cmd_i   (rd_cmd),
    .half_lat_i (cfg_half_lat_i),
    .rd_data_i  (rd_data_i),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );

  assert_one_nop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd |-> !$past(rd_cmd));
  assert_two_nop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && cfg_two_nop_i && $past(cfg_two_nop_i)) |-> !$past(rd_cmd, 2));
  assert_read_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_write_i |-> req_ready_o);
endmodule

// File: tb/ddr_sram_sched_test.sv
`timescale 1ns/1ps
module ddr_sram_sched_test;
  localparam int BANKS = 4, ADDR_W = 20, DATA_W = 18, BE_W = 2;
  localparam int BANK_W = $clog2(BANKS), DEV_W = ADDR_W - BANK_W;

  logic clk = 0, rst_n = 0;
  logic two_nop = 0, half_lat = 0;
  logic req_valid = 0, req_write = 0;
  logic req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [2*DATA_W-1:0] req_wdata = '0, rd_data_in = '0, rd_data_out, wd;
  logic [2*BE_W-1:0] req_be = '0, be_n;
  logic [BANKS-1:0] ld_n;
  logic rw, rd_valid;
  logic [DEV_W-1:0] addr;

  always #2 clk = ~clk;

  ddr_sram_sched #(.BANKS(BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_two_nop_i(two_nop), .cfg_half_lat_i(half_lat),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .ld_n_o(ld_n), .rw_o(rw), .addr_o(addr), .wd_o(wd), .be_n_o(be_n),
    .rd_data_i(rd_data_in), .rd_data_o(rd_data_out), .rd_valid_o(rd_valid));

  typedef struct {
    logic v, w;
    logic [ADDR_W-1:0] a;
    logic [2*DATA_W-1:0] d;
    logic [2*BE_W-1:0] be;
  } req_t;

  int checks = 0, errors = 0;
  req_t p1, p2;
  logic [2:0] rh = '0;
  int m_gap = 3;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [BANKS-1:0] exp_ld(input req_t r);
    logic [BANKS-1:0] m = '1;
    if (r.v) m[r.a[ADDR_W-1 -: BANK_W]] = 1'b0;
    return m;
  endfunction

  function automatic bit exp_ready(input logic w, input int gap, input logic tn);
    return !(w && gap < (tn ? 2 : 1));
  endfunction

  // called at a falling edge; checks outputs of the last edge, then drives
  task automatic step(input logic v, input logic w, input logic [ADDR_W-1:0] a);
    logic [BANKS-1:0] el;
    bit er, acc;
    el = exp_ld(p1);
    chk(ld_n == el, "R2 strobe", 64'(ld_n), 64'(el));
    if (p1.v) begin
      chk(rw == !p1.w, "R2 rw", 64'(rw), 64'(!p1.w));
      chk(addr == p1.a[DEV_W-1:0], "R2 addr", 64'(addr), 64'(p1.a[DEV_W-1:0]));
    end
    if (p2.v && p2.w) begin
      chk(wd == p2.d, "R6 data", 64'(wd), 64'(p2.d));
      chk(be_n == ~p2.be, "R6 be", 64'(be_n), 64'(~p2.be));
    end else
      chk(&be_n, "R6 idle be", 64'(be_n), 64'hf);
    rh = {rh[1:0], p1.v && !p1.w};
    er = half_lat ? rh[2] : rh[1];
    chk(rd_valid == er, half_lat ? "R8 R9 valid" : "R7 R9 valid", 64'(rd_valid), 64'(er));
    if (er) chk(rd_data_out == rd_data_in, "R7 R8 data", 64'(rd_data_out), 64'(rd_data_in));
    if (p1.v && !p1.w) m_gap = 0; else if (m_gap < 3) m_gap++;
    req_valid = v; req_write = w; req_addr = a;
    req_wdata = {$urandom, $urandom};
    req_be = 4'($urandom);
    rd_data_in = {$urandom, $urandom};
    #1;
    er = exp_ready(w, m_gap, two_nop);
    if (w && !er)
      chk(req_ready == er, "R3 hold", 64'(req_ready), 64'(er));
    else if (w && m_gap == (two_nop ? 2 : 1))
      chk(req_ready == er, "R5 release", 64'(req_ready), 64'(er));
    else
      chk(req_ready == er, "R4 ready", 64'(req_ready), 64'(er));
    acc = v && req_ready;
    p2 = p1;
    p1 = '{acc, w, a, req_wdata, req_be};
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) step(0, 0, '0);
  endtask

  initial begin
    int lim = 150000;
    repeat (lim) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", lim, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    p1 = '{0, 0, '0, '0, '0}; p2 = p1;
    repeat (3) @(negedge clk);
    chk(&ld_n, "R1 strobes", 64'(ld_n), 64'hf);
    chk(&be_n, "R1 be", 64'(be_n), 64'hf);
    chk(!rd_valid, "R1 valid", 64'(rd_valid), 0);
    chk(req_ready, "R1 ready", 64'(req_ready), 1);
    rst_n = 1;
    @(negedge clk);
    chk(&ld_n && !rd_valid, "R1 after reset", 64'(ld_n), 64'hf);
    // back-to-back reads across all banks, then read->write with one idle
    for (int b = 0; b < BANKS; b++) step(1, 0, {BANK_W'(b), DEV_W'(b + 5)});
    step(1, 1, 20'h0_0011);
    step(1, 1, 20'h0_0011);
    step(1, 1, 20'h4_0022);
    step(1, 0, 20'hc_0033);
    drain();
    // two idle cycles
    two_nop = 1;
    step(1, 0, 20'h8_0001);
    step(1, 1, 20'h8_0002);
    step(1, 1, 20'h8_0002);
    step(1, 1, 20'h8_0002);
    drain();
    // half-cycle latency with consecutive reads
    half_lat = 1;
    step(1, 0, 20'h1_0000);
    step(1, 0, 20'h2_0000);
    step(0, 0, '0);
    step(1, 0, 20'h3_0000);
    drain();
    for (int ph = 0; ph < 8; ph++) begin
      half_lat = ph[0];
      for (int i = 0; i < 400; i++) begin
        if (i % 37 == 0) two_nop = 1'($urandom);
        step(1'($urandom_range(0, 9) < 7), 1'($urandom), ADDR_W'($urandom));
      end
      drain();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule